// File: doc/BRIEF.md
# Byte-Parallel Configuration Port Serializer

This block is the host-facing configuration port of a programmable device. A host places a byte on an 8-bit data bus and pulses an active-low write strobe while both chip selects are active. The block brings the strobe, chip selects and data into its configuration-clock domain through a two-stage synchronizer. It takes the byte when the strobe is released, then sends it bit by bit on a serial output.

Ready goes low for the whole transfer. The host learns that the transfer has finished in one of two ways: it watches the ready pin, or it pulls the read strobe low and reads the same status on data bit 7. The serial output moves only on falling edges of the configuration clock. Each byte is sent least significant bit first, and the output keeps the last bit sent until the next byte starts. A write that arrives during a transfer is dropped, and a sticky overrun flag records it.

Top module: `cfg_port_ser`

## Requirements
- R1: After reset, `rdy` is 1, `dout` is 0, `overrun` is 0, and `d7_en` is 0 while `rd_n` is 1.
- R2: A byte is accepted only if `wr_n` is low while `cs0_n` is low and `cs1` is high. A strobe with `cs0_n` high or `cs1` low leaves `rdy` high and starts no serial bits.
- R3: After a byte is accepted, `rdy` stays low for exactly 8 configuration-clock periods, and then returns high.
- R4: `dout` changes only on falling edges of `clk`. It holds the same value on both sides of every rising edge.
- R5: Bits leave on `dout` in the order bit 0, bit 1, up to bit 7. After bit 7, `dout` holds that bit while the port is idle.
- R6: While `rd_n` is low, `d7_en` is 1 and `d7_out` equals `rdy`, so the end of busy is seen at the same time on both. While `rd_n` is high, `d7_en` is 0. Bits 6 to 0 of the bus are never driven.
- R7: A write accepted by the strobe logic while `rdy` is low is ignored: no extra bits are sent. It sets `overrun` to 1, and `overrun` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| wr_n | input | 1 | Active-low write strobe |
| cs0_n | input | 1 | Active-low chip select |
| cs1 | input | 1 | Active-high chip select |
| rd_n | input | 1 | Active-low read strobe for status |
| host_d | input | W | Host data bus |
| rdy | output | 1 | 1 when idle, 0 while a byte is being sent |
| d7_out | output | 1 | Status value for data bit 7 during a read |
| d7_en | output | 1 | Output enable for data bit 7 |
| dout | output | 1 | Serial data, updated on falling edges |
| overrun | output | 1 | Sticky flag for a write dropped while busy |

## Verification
A bit index that drifts, or a data register loaded at the wrong time, shows on `dout` within one transfer. The serial stream then stops matching the written bytes taken least significant bit first, and the mismatch is visible no later than 8 clock periods after the write. A busy flag that clears too early or too late changes the number of low-ready periods in that same transfer. An overrun that is missed, or that fails to stick, shows on `overrun` as soon as the second write is synchronized, which is about three cycles after its strobe is released.

// File: rtl/cfg_port_ser.sv
module cfg_port_ser #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_n,
  input  logic         cs0_n,
  input  logic         cs1,
  input  logic         rd_n,
  input  logic [W-1:0] host_d,
  output logic         rdy,
  output logic         d7_out,
  output logic         d7_en,
  output logic         dout,
  output logic         overrun
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [SYNC-1:0] wa_sync;
  logic [W-1:0]    d_sync [SYNC];
  logic            wa_prev;
  logic            take;
  logic            busy;
  logic [W-1:0]    sh;
  logic [CW-1:0]   idx;

  wire wa_raw = ~wr_n & ~cs0_n & cs1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wa_sync <= '0;
      wa_prev <= 1'b0;
      for (int i = 0; i < SYNC; i++) d_sync[i] <= '0;
    end else begin
      wa_sync   <= {wa_sync[SYNC-2:0], wa_raw};
      wa_prev   <= wa_sync[SYNC-1];
      d_sync[0] <= host_d;
      for (int i = 1; i < SYNC; i++) d_sync[i] <= d_sync[i-1];
    end
  end

  assign take = wa_prev & ~wa_sync[SYNC-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sh      <= '0;
      idx     <= '0;
      overrun <= 1'b0;
    end else begin
      if (take && busy) overrun <= 1'b1;
      if (take && !busy) begin
        sh   <= d_sync[SYNC-1];
        idx  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        if (idx == CW'(W-1)) busy <= 1'b0;
        else                 idx  <= idx + 1'b1;
      end
    end
  end

  always_ff @(negedge clk) begin
    if (!rst_n)    dout <= 1'b0;
    else if (busy) dout <= sh[idx];
  end

  assign rdy    = ~busy;
  assign d7_en  = ~rd_n;
  assign d7_out = ~rd_n & ~busy;
endmodule

// File: rtl/cfg_port_ser_chk.sv
module cfg_port_ser_chk (
  input logic clk,
  input logic rst_n,
  input logic rdy,
  input logic dout,
  input logic overrun,
  input logic take
);
  logic [4:0] lowc;

  always_ff @(posedge clk) begin
    if (!rst_n)    lowc <= '0;
    else if (!rdy) lowc <= lowc + 1'b1;
    else           lowc <= '0;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (rdy && !dout && !overrun));

  p_busy_from_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(take));

  p_busy_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |-> lowc < 5'd8);

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> lowc == 5'd8);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && $past(rdy)) |-> $stable(dout));

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overrun) |-> overrun);

  p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(take && !rdy));
endmodule

bind cfg_port_ser cfg_port_ser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .dout(dout),
  .overrun(overrun), .take(take)
);

// File: tb/cfg_port_ser_tb.sv
module cfg_port_ser_tb;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h3C};

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_n = 1'b1, cs0_n = 1'b1, cs1 = 1'b0, rd_n = 1'b1;
  logic [7:0] host_d = '0;
  logic rdy, d7_out, d7_en, dout, overrun;

  int checks = 0, errors = 0;
  int nbits = 0, glitches = 0;
  logic [255:0] stream = '0;
  logic pre;

  always #(CLK_P/2) clk = ~clk;

  cfg_port_ser u_dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cs0_n(cs0_n), .cs1(cs1),
    .rd_n(rd_n), .host_d(host_d), .rdy(rdy), .d7_out(d7_out),
    .d7_en(d7_en), .dout(dout), .overrun(overrun)
  );

  always @(negedge clk) begin
    #2;
    if (rst_n && !rdy) begin
      if (nbits < 256) stream[nbits] = dout;
      nbits++;
    end
  end

  always @(posedge clk) begin
    pre = dout;
    #1;
    if (rst_n && dout !== pre) glitches++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic write_byte(logic [7:0] b, logic c0, logic c1);
    @(negedge clk);
    host_d = b; cs0_n = c0; cs1 = c1; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    cs0_n = 1'b1; cs1 = 1'b0;
  endtask

  task automatic poll_ready(string req);
    int n = 0;
    rd_n = 1'b0;
    @(negedge clk); #2;
    while (!(d7_en && d7_out) && n < 40) begin
      chk({req, " d7 equals rdy"}, d7_out, rdy);
      @(negedge clk); #2;
      n++;
    end
    chk({req, " ready seen on d7 and pin"}, {d7_out, rdy}, 2'b11);
    rd_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    do_reset();
    #2;
    chk("R1 rdy", rdy, 1);
    chk("R1 dout", dout, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 d7_en idle", d7_en, 0);

    for (int i = 0; i < NV; i++) begin
      base = nbits;
      write_byte(VEC[i], 1'b0, 1'b1);
      chk("R6 busy seen on d7", {d7_en, d7_out}, 2'b00);
      poll_ready("R6");
      chk("R3 busy length", nbits - base, 8);
      chk("R5 lsb-first byte", stream[base +: 8], VEC[i]);
      @(negedge clk); #2;
      chk("R5 hold last bit", dout, VEC[i][7]);
      chk("R7 no overrun", overrun, 0);
    end
    chk("R5 whole stream", stream[NV*8-1:0] == {VEC[5], VEC[4], VEC[3], VEC[2], VEC[1], VEC[0]}, 1);

    base = nbits;
    write_byte(8'h5A, 1'b1, 1'b1);
    repeat (12) @(negedge clk); #2;
    chk("R2 cs0 high ignored rdy", rdy, 1);
    chk("R2 cs0 high no bits", nbits - base, 0);
    write_byte(8'h5A, 1'b0, 1'b0);
    repeat (12) @(negedge clk); #2;
    chk("R2 cs1 low ignored rdy", rdy, 1);
    chk("R2 cs1 low no bits", nbits - base, 0);
    chk("R5 idle dout kept", dout, VEC[NV-1][7]);

    rd_n = 1'b0; #1;
    chk("R6 idle read", {d7_en, d7_out}, 2'b11);
    rd_n = 1'b1; #1;
    chk("R6 released", d7_en, 0);

    base = nbits;
    write_byte(8'hC3, 1'b0, 1'b1);
    write_byte(8'h7E, 1'b0, 1'b1);
    poll_ready("R7");
    chk("R7 overrun set", overrun, 1);
    repeat (15) @(negedge clk); #2;
    chk("R7 second byte dropped", nbits - base, 8);
    chk("R7 first byte intact", stream[base +: 8], 8'hC3);
    chk("R7 overrun sticky", overrun, 1);
    chk("R4 no change at rising edge", glitches, 0);

    do_reset();
    #2;
    chk("R7 cleared by reset", overrun, 0);
    chk("R1 dout after reset", dout, 0);
    chk("R1 rdy after reset", rdy, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule